// File: doc/BRIEF.md
# Dual-Compare 8-Bit Timer Pair

This block holds two identical 8-bit timer channels behind one small register bus. Each channel has an up-counter that moves only on cycles where a selected clock-enable tick is high. Two compare registers watch the counter continuously. A match sets a sticky status flag, can restart the counter, and can drive, release or toggle a waveform output. The clock prescaler sits outside the block, and its prescaled ticks arrive as enable inputs. Each channel can also be restarted from an external clear input.

Software reaches each channel's counter, compare registers, control register and status register with byte accesses. It can also treat the two channels as one 16-bit pair, in which channel 0 supplies the high byte and channel 1 the low byte. Status flags use a read-then-clear handshake, so a flag that software has not yet seen is never lost.

Top module: `dual_cmp_timer`

## Requirements
- R1: After reset, every counter reads 0x00, both compare registers read 0xFF, control and status read 0x00, and both outputs are 0.
- R2: Control bits [1:0] select which tick input enables a channel. The counter adds one on a clock edge only when that tick is high. Any other tick has no effect.
- R3: A bus write to a counter loads the written value and overrides counting and clearing in that cycle.
- R4: Status bit 1 is set when the counter equals compare register A. Status bit 2 is set when it equals compare register B.
- R5: Status bit 0 is set when a tick moves the counter from 0xFF to 0x00 by counting. A clear that happens at 0xFF does not set it.
- R6: Writing 0 to status bits [2:0] clears only the flags that were last read as 1. Writing 1 to those bits, or writing 0 without a prior read, leaves them unchanged.
- R7: Control bits [3:2] pick the clear source. 00 means no clear, 01 means match A and 10 means match B. On a tick while the selected match holds, the counter goes to 0x00 instead of counting.
- R8: With clear source 11, a tick while the channel's external clear input is high sends the counter to 0x00. Without a tick, or with any other clear source, the external clear input has no effect.
- R9: In the cycle in which a compare register is written, no match with that register is seen, so it neither clears the counter nor starts a match event.
- R10: A match event is the first cycle of equality. Status bits [4:3] set the output action for match A and bits [6:5] set it for match B: 00 keeps the output, 01 drives 0, 10 drives 1 and 11 toggles. The output changes on the edge that ends the match-event cycle.
- R11: When match events for A and B fall in the same cycle, only match B's action is applied.
- R12: Register index busAddr[2:0] selects the register: 0 counter, 1 compare A, 2 compare B, 3 control, 4 status. On a byte access (busWide=0), busAddr[3] selects the channel, data uses bits [7:0], and read data bits [15:8] are zero. On a wide access, channel 0 uses bits [15:8] and channel 1 uses bits [7:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tick | input | TICK_COUNT | Prescaled count-enable ticks, shared by both channels |
| extClr | input | 2 | External counter clear, one per channel |
| busSel | input | 1 | Bus access strobe |
| busWrite | input | 1 | 1 = write, 0 = read |
| busWide | input | 1 | 1 = 16-bit paired access to both channels |
| busAddr | input | 4 | Channel bit [3] and register index [2:0] |
| busWdata | input | 16 | Write data |
| busRdata | output | 16 | Read data, combinational from the address |
| timerOut | output | 2 | Waveform output, one per channel |

## Verification
The bench builds the block with TICK_COUNT=4. That lets it try every pairing of the selected slot with every single tick input. Because the counters are 8 bits wide, a match-A clear sweep across compare values from 0 to 255 runs every period to completion in a short run, including a clear at 0xFF that must not raise overflow. The same small width means every output action, the A/B priority in both directions and the write-blocked compare can each be set up directly and compared against a counter model held in the bench.

// File: rtl/dct_pkg.sv
package dct_pkg;
  localparam int BYTE_W   = 8;
  localparam int WORD_W   = 2 * BYTE_W;
  localparam int IDX_W    = 3;
  localparam int ADDR_W   = IDX_W + 1;
  localparam int NUM_CH   = 2;
  localparam int TSEL_W   = 2;
  localparam int TSLOTS   = 1 << TSEL_W;
  localparam int NUM_FLAG = 3;

  typedef enum logic [IDX_W-1:0] {
    REG_CNT  = 3'd0,
    REG_CMPA = 3'd1,
    REG_CMPB = 3'd2,
    REG_CTRL = 3'd3,
    REG_STAT = 3'd4
  } regIdx_e;

  typedef enum logic [1:0] {
    CLR_NONE   = 2'b00,
    CLR_MATCHA = 2'b01,
    CLR_MATCHB = 2'b10,
    CLR_EXT    = 2'b11
  } clrSel_e;

  typedef enum logic [1:0] {
    ACT_KEEP   = 2'b00,
    ACT_LOW    = 2'b01,
    ACT_HIGH   = 2'b10,
    ACT_TOGGLE = 2'b11
  } outAct_e;

  // strobes from bus control to one channel datapath
  typedef struct packed {
    logic              wrCnt;
    logic              wrCmpA;
    logic              wrCmpB;
    logic              wrCtrl;
    logic              wrStat;
    logic              rdStat;
    logic [BYTE_W-1:0] wdata;
  } chanStrobe_t;

  // register view of one channel, as seen by software
  typedef struct packed {
    logic [BYTE_W-1:0] cnt;
    logic [BYTE_W-1:0] cmpA;
    logic [BYTE_W-1:0] cmpB;
    logic [BYTE_W-1:0] ctrl;
    logic [BYTE_W-1:0] stat;
  } chanView_t;
endpackage

// File: rtl/dct_busctl.sv
module dct_busctl
  import dct_pkg::*;
(
  input  logic                          busSel,
  input  logic                          busWrite,
  input  logic                          busWide,
  input  logic [ADDR_W-1:0]             busAddr,
  input  logic [WORD_W-1:0]             busWdata,
  input  chanView_t [NUM_CH-1:0]        view,
  output chanStrobe_t [NUM_CH-1:0]      stb,
  output logic [WORD_W-1:0]             busRdata
);
  logic [IDX_W-1:0] regIdx;
  logic             chanBit;

  assign regIdx  = busAddr[IDX_W-1:0];
  assign chanBit = busAddr[ADDR_W-1];

  function automatic logic [BYTE_W-1:0] pickReg(chanView_t v, logic [IDX_W-1:0] idx);
    logic [BYTE_W-1:0] r;
    case (regIdx_e'(idx))
      REG_CNT:  r = v.cnt;
      REG_CMPA: r = v.cmpA;
      REG_CMPB: r = v.cmpB;
      REG_CTRL: r = v.ctrl;
      REG_STAT: r = v.stat;
      default:  r = '0;
    endcase
    return r;
  endfunction

  // write / read-strobe decode; wide access hits both channels
  always_comb begin
    for (int c = 0; c < NUM_CH; c++) begin
      logic hit;
      hit = busSel && (busWide || (chanBit == 1'(c)));
      stb[c] = '0;
      if (busWide && c == 0)
        stb[c].wdata = busWdata[WORD_W-1:BYTE_W];
      else
        stb[c].wdata = busWdata[BYTE_W-1:0];
      if (hit) begin
        case (regIdx_e'(regIdx))
          REG_CNT:  stb[c].wrCnt  = busWrite;
          REG_CMPA: stb[c].wrCmpA = busWrite;
          REG_CMPB: stb[c].wrCmpB = busWrite;
          REG_CTRL: stb[c].wrCtrl = busWrite;
          REG_STAT: begin
            stb[c].wrStat = busWrite;
            stb[c].rdStat = !busWrite;
          end
          default: ;
        endcase
      end
    end
  end

  // read mux: channel 0 is the high byte of the paired word
  always_comb begin
    if (busWide)
      busRdata = {pickReg(view[0], regIdx), pickReg(view[1], regIdx)};
    else if (chanBit)
      busRdata = {{BYTE_W{1'b0}}, pickReg(view[1], regIdx)};
    else
      busRdata = {{BYTE_W{1'b0}}, pickReg(view[0], regIdx)};
  end
endmodule

// File: rtl/dct_flag.sv
module dct_flag (
  input  logic clk,
  input  logic rstN,
  input  logic setEvt,
  input  logic rdStrobe,
  input  logic wrStrobe,
  input  logic wrBit,
  output logic flagQ
);
  logic armedQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagQ  <= 1'b0;
      armedQ <= 1'b0;
    end else begin
      // a hardware set beats a software clear in the same cycle
      if (setEvt)
        flagQ <= 1'b1;
      else if (wrStrobe && armedQ && !wrBit)
        flagQ <= 1'b0;
      if (rdStrobe)
        armedQ <= flagQ;
      else if (wrStrobe)
        armedQ <= 1'b0;
    end
  end
endmodule

// File: rtl/dct_chan.sv
module dct_chan
  import dct_pkg::*;
#(
  parameter int TICK_COUNT = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [TICK_COUNT-1:0] tick,
  input  logic                  extClr,
  input  chanStrobe_t           stb,
  output chanView_t             view,
  output logic                  pinOut
);
  logic [BYTE_W-1:0]   cntQ, cmpAQ, cmpBQ;
  logic [TSEL_W-1:0]   tickSelQ;
  clrSel_e             clrSelQ;
  outAct_e             actAQ, actBQ;
  logic                eqA, eqB, eqAPrev, eqBPrev;
  logic                evtA, evtB;
  logic                tickNow, clrNow, wrapEvt;
  logic                pinQ, pinNext;
  logic [TSLOTS-1:0]   tickPad;
  logic [NUM_FLAG-1:0] flagSet, flagQ;

  always_comb begin
    tickPad = '0;
    tickPad[TICK_COUNT-1:0] = tick;
  end
  assign tickNow = tickPad[tickSelQ];

  // compare against a register is blanked while it is being written
  assign eqA  = (cntQ == cmpAQ) && !stb.wrCmpA;
  assign eqB  = (cntQ == cmpBQ) && !stb.wrCmpB;
  assign evtA = eqA && !eqAPrev;
  assign evtB = eqB && !eqBPrev;

  always_comb begin
    case (clrSelQ)
      CLR_MATCHA: clrNow = eqA;
      CLR_MATCHB: clrNow = eqB;
      CLR_EXT:    clrNow = extClr;
      default:    clrNow = 1'b0;
    endcase
  end

  assign wrapEvt = !stb.wrCnt && tickNow && !clrNow && (cntQ == '1);

  function automatic logic applyAct(outAct_e act, logic cur);
    logic r;
    case (act)
      ACT_LOW:    r = 1'b0;
      ACT_HIGH:   r = 1'b1;
      ACT_TOGGLE: r = !cur;
      default:    r = cur;
    endcase
    return r;
  endfunction

  always_comb begin
    pinNext = pinQ;
    if (evtB)
      pinNext = applyAct(actBQ, pinQ);
    else if (evtA)
      pinNext = applyAct(actAQ, pinQ);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ     <= '0;
      cmpAQ    <= '1;
      cmpBQ    <= '1;
      tickSelQ <= '0;
      clrSelQ  <= CLR_NONE;
      actAQ    <= ACT_KEEP;
      actBQ    <= ACT_KEEP;
      eqAPrev  <= 1'b0;
      eqBPrev  <= 1'b0;
      pinQ     <= 1'b0;
    end else begin
      if (stb.wrCnt)
        cntQ <= stb.wdata;
      else if (tickNow)
        cntQ <= clrNow ? '0 : cntQ + 1'b1;
      if (stb.wrCmpA) cmpAQ <= stb.wdata;
      if (stb.wrCmpB) cmpBQ <= stb.wdata;
      if (stb.wrCtrl) begin
        tickSelQ <= stb.wdata[TSEL_W-1:0];
        clrSelQ  <= clrSel_e'(stb.wdata[TSEL_W+1:TSEL_W]);
      end
      if (stb.wrStat) begin
        actAQ <= outAct_e'(stb.wdata[4:3]);
        actBQ <= outAct_e'(stb.wdata[6:5]);
      end
      eqAPrev <= eqA;
      eqBPrev <= eqB;
      pinQ    <= pinNext;
    end
  end

  assign flagSet = {evtB, evtA, wrapEvt};

  for (genvar f = 0; f < NUM_FLAG; f++) begin : g_flag
    dct_flag u_flag (
      .clk      (clk),
      .rstN     (rstN),
      .setEvt   (flagSet[f]),
      .rdStrobe (stb.rdStat),
      .wrStrobe (stb.wrStat),
      .wrBit    (stb.wdata[f]),
      .flagQ    (flagQ[f])
    );
  end

  assign view.cnt  = cntQ;
  assign view.cmpA = cmpAQ;
  assign view.cmpB = cmpBQ;
  assign view.ctrl = {{(BYTE_W-2*TSEL_W){1'b0}}, clrSelQ, tickSelQ};
  assign view.stat = {1'b0, actBQ, actAQ, flagQ};
  assign pinOut    = pinQ;
endmodule

// File: rtl/dual_cmp_timer.sv
module dual_cmp_timer
  import dct_pkg::*;
#(
  parameter int TICK_COUNT = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [TICK_COUNT-1:0] tick,
  input  logic [NUM_CH-1:0]     extClr,
  input  logic                  busSel,
  input  logic                  busWrite,
  input  logic                  busWide,
  input  logic [ADDR_W-1:0]     busAddr,
  input  logic [WORD_W-1:0]     busWdata,
  output logic [WORD_W-1:0]     busRdata,
  output logic [NUM_CH-1:0]     timerOut
);
  chanStrobe_t [NUM_CH-1:0] stb;
  chanView_t   [NUM_CH-1:0] view;

  dct_busctl u_busctl (
    .busSel   (busSel),
    .busWrite (busWrite),
    .busWide  (busWide),
    .busAddr  (busAddr),
    .busWdata (busWdata),
    .view     (view),
    .stb      (stb),
    .busRdata (busRdata)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    dct_chan #(.TICK_COUNT(TICK_COUNT)) u_chan (
      .clk    (clk),
      .rstN   (rstN),
      .tick   (tick),
      .extClr (extClr[c]),
      .stb    (stb[c]),
      .view   (view[c]),
      .pinOut (timerOut[c])
    );
  end
endmodule

// File: rtl/dual_cmp_timer_chk.sv
module dual_cmp_timer_chk
  import dct_pkg::*;
#(
  parameter int TICK_COUNT = 4
) (
  input logic                  clk,
  input logic                  rstN,
  input logic [TICK_COUNT-1:0] tick,
  input logic                  busSel,
  input logic                  busWrite,
  input chanView_t [NUM_CH-1:0] view,
  input logic [NUM_CH-1:0]     timerOut
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    // R2: counter moves only after a tick or a bus write
    p_cnt_moves_r2: assert property (@(posedge clk) disable iff (!rstN)
      !$stable(view[c].cnt) |-> $past(|tick || (busSel && busWrite)));

    // R4: flag A rises only after the counter matched compare A
    p_flag_a_r4: assert property (@(posedge clk) disable iff (!rstN)
      $rose(view[c].stat[1]) |-> $past(view[c].cnt == view[c].cmpA));

    // R4: flag B rises only after the counter matched compare B
    p_flag_b_r4: assert property (@(posedge clk) disable iff (!rstN)
      $rose(view[c].stat[2]) |-> $past(view[c].cnt == view[c].cmpB));

    // R5: overflow rises only when the counter left 0xFF
    p_ovf_rise_r5: assert property (@(posedge clk) disable iff (!rstN)
      $rose(view[c].stat[0]) |-> ($past(view[c].cnt) == '1 && view[c].cnt == '0));

    // R10: output changes only after a cycle with a compare match
    p_out_change_r10: assert property (@(posedge clk) disable iff (!rstN)
      !$stable(timerOut[c]) |->
        $past(view[c].cnt == view[c].cmpA || view[c].cnt == view[c].cmpB));
  end
endmodule

bind dual_cmp_timer dual_cmp_timer_chk #(.TICK_COUNT(TICK_COUNT)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .tick     (tick),
  .busSel   (busSel),
  .busWrite (busWrite),
  .view     (view),
  .timerOut (timerOut)
);

// File: tb/dual_cmp_timer_test.sv
`timescale 1ns/1ps
module dual_cmp_timer_test;
  localparam int TICKS = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [TICKS-1:0] tick = '0;
  logic [1:0]  extClr = '0;
  logic        busSel = 1'b0;
  logic        busWrite = 1'b0;
  logic        busWide = 1'b0;
  logic [3:0]  busAddr = '0;
  logic [15:0] busWdata = '0;
  logic [15:0] busRdata;
  logic [1:0]  timerOut;

  int nCmp = 0;
  int nBad = 0;
  bit done = 1'b0;
  logic [15:0] r;

  always #2 clk = ~clk;

  dual_cmp_timer #(.TICK_COUNT(TICKS)) uut (
    .clk(clk), .rstN(rstN), .tick(tick), .extClr(extClr),
    .busSel(busSel), .busWrite(busWrite), .busWide(busWide),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .timerOut(timerOut)
  );

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    nCmp++;
    if (got !== exp) begin
      nBad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input bit ch, input logic [2:0] idx, input logic [7:0] d);
    @(negedge clk);
    busSel = 1; busWrite = 1; busWide = 0; busAddr = {ch, idx}; busWdata = {8'h00, d};
    @(negedge clk);
    busSel = 0; busWrite = 0;
  endtask

  task automatic wrTick(input bit ch, input logic [2:0] idx, input logic [7:0] d,
                        input logic [TICKS-1:0] m);
    @(negedge clk);
    busSel = 1; busWrite = 1; busWide = 0; busAddr = {ch, idx}; busWdata = {8'h00, d};
    tick = m;
    @(negedge clk);
    busSel = 0; busWrite = 0; tick = '0;
  endtask

  task automatic wrW(input logic [2:0] idx, input logic [15:0] d);
    @(negedge clk);
    busSel = 1; busWrite = 1; busWide = 1; busAddr = {1'b0, idx}; busWdata = d;
    @(negedge clk);
    busSel = 0; busWrite = 0; busWide = 0;
  endtask

  task automatic rd(input bit ch, input logic [2:0] idx, output logic [15:0] v);
    @(negedge clk);
    busSel = 1; busWrite = 0; busWide = 0; busAddr = {ch, idx};
    #1 v = busRdata;
    @(negedge clk);
    busSel = 0;
  endtask

  task automatic rdW(input logic [2:0] idx, output logic [15:0] v);
    @(negedge clk);
    busSel = 1; busWrite = 0; busWide = 1; busAddr = {1'b0, idx};
    #1 v = busRdata;
    @(negedge clk);
    busSel = 0; busWide = 0;
  endtask

  task automatic tk(input logic [TICKS-1:0] m);
    @(negedge clk);
    tick = m;
    @(negedge clk);
    tick = '0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic clrFlags(input bit ch);
    logic [15:0] t;
    rd(ch, 3'd4, t);
    wr(ch, 3'd4, 8'h00);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nBad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end

  initial begin
    int m;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int c = 0; c < 2; c++) begin
      rd(c[0], 3'd0, r); chk("R1 cnt", r, 16'h0000);
      rd(c[0], 3'd1, r); chk("R1 cmpA", r, 16'h00FF);
      rd(c[0], 3'd2, r); chk("R1 cmpB", r, 16'h00FF);
      rd(c[0], 3'd3, r); chk("R1 ctrl", r, 16'h0000);
      rd(c[0], 3'd4, r); chk("R1 stat", r, 16'h0000);
    end
    chk("R1 out", {14'd0, timerOut}, 16'h0000);

    // R2 every selected slot against every single tick
    for (int s = 0; s < TICKS; s++) begin
      wr(0, 3'd3, 8'(s));
      wr(0, 3'd0, 8'h00);
      for (int k = 0; k < TICKS; k++) tk(TICKS'(1 << k));
      rd(0, 3'd0, r); chk("R2 only selected tick counts", r, 16'h0001);
      tk('1);
      rd(0, 3'd0, r); chk("R2 all ticks count once", r, 16'h0002);
    end

    // R3 write beats clear and count
    wr(0, 3'd3, 8'h04);
    wr(0, 3'd1, 8'h10);
    wr(0, 3'd0, 8'h10);
    wrTick(0, 3'd0, 8'h55, 4'b0001);
    rd(0, 3'd0, r); chk("R3 write priority", r, 16'h0055);

    // R5 overflow, R6 clear handshake
    wr(0, 3'd3, 8'h00);
    clrFlags(0);
    wr(0, 3'd0, 8'hFE);
    tk(4'b0001); tk(4'b0001);
    wr(0, 3'd4, 8'h00);
    rd(0, 3'd0, r); chk("R5 wrap to zero", r, 16'h0000);
    rd(0, 3'd4, r); chk("R6 clear without read ignored", r & 16'h0001, 16'h0001);
    wr(0, 3'd4, 8'h00);
    rd(0, 3'd4, r); chk("R6 clear after read", r & 16'h0001, 16'h0000);
    wr(0, 3'd4, 8'h07);
    rd(0, 3'd4, r); chk("R6 write one ignored", r & 16'h0007, 16'h0000);

    // R7 match-A clear sweep on channel 1, R4 flag A, R5 no overflow on clear
    wr(1, 3'd3, 8'h04);
    for (int v = 0; v < 256; v += 5) begin
      clrFlags(1);
      wr(1, 3'd1, 8'(v));
      wr(1, 3'd0, 8'h00);
      m = 0;
      for (int t = 0; t < v + 3; t++) begin
        tk(4'b0001);
        m = (m == v) ? 0 : m + 1;
        rd(1, 3'd0, r); chk("R7 clear on match A", r, 16'(m));
      end
      rd(1, 3'd4, r);
      chk("R4 flag A set", r & 16'h0002, 16'h0002);
      chk("R5 no overflow on clear", r & 16'h0001, 16'h0000);
    end

    // R7 match-B clear, R4 both flags
    wr(0, 3'd3, 8'h08);
    wr(0, 3'd1, 8'h03);
    wr(0, 3'd2, 8'h0A);
    wr(0, 3'd0, 8'h00);
    clrFlags(0);
    m = 0;
    for (int t = 0; t < 25; t++) begin
      tk(4'b0001);
      m = (m == 10) ? 0 : m + 1;
    end
    rd(0, 3'd0, r); chk("R7 clear on match B", r, 16'(m));
    rd(0, 3'd4, r); chk("R4 flags A and B", r & 16'h0007, 16'h0006);

    // R8 external clear
    wr(0, 3'd3, 8'h0C);
    wr(0, 3'd0, 8'h20);
    extClr = 2'b01;
    idle(2);
    rd(0, 3'd0, r); chk("R8 ext clear needs tick", r, 16'h0020);
    tk(4'b0001);
    extClr = 2'b00;
    rd(0, 3'd0, r); chk("R8 ext clear on tick", r, 16'h0000);
    wr(0, 3'd3, 8'h00);
    wr(0, 3'd0, 8'h20);
    extClr = 2'b01;
    tk(4'b0001);
    extClr = 2'b00;
    rd(0, 3'd0, r); chk("R8 ext clear ignored when not selected", r, 16'h0021);

    // R9 compare blocked while written
    wr(0, 3'd3, 8'h04);
    wr(0, 3'd1, 8'h03);
    wr(0, 3'd0, 8'h00);
    tk(4'b0001); tk(4'b0001); tk(4'b0001);
    wrTick(0, 3'd1, 8'h03, 4'b0001);
    rd(0, 3'd0, r); chk("R9 clear blocked during compare write", r, 16'h0004);
    wr(0, 3'd0, 8'h03);
    tk(4'b0001);
    rd(0, 3'd0, r); chk("R9 clear works otherwise", r, 16'h0000);

    // R10 output actions on channel 1
    wr(1, 3'd3, 8'h00);
    wr(1, 3'd1, 8'h02);
    wr(1, 3'd2, 8'h05);
    wr(1, 3'd4, 8'h30);
    wr(1, 3'd0, 8'h00);
    tk(4'b0001); tk(4'b0001); idle(1);
    chk("R10 drive high on A", {15'd0, timerOut[1]}, 16'h0001);
    tk(4'b0001); tk(4'b0001); tk(4'b0001); idle(1);
    chk("R10 drive low on B", {15'd0, timerOut[1]}, 16'h0000);
    wr(1, 3'd4, 8'h18);
    wr(1, 3'd0, 8'h01);
    tk(4'b0001); idle(1);
    chk("R10 toggle on A", {15'd0, timerOut[1]}, 16'h0001);
    wr(1, 3'd4, 8'h00);
    wr(1, 3'd0, 8'h01);
    tk(4'b0001); idle(1);
    chk("R10 keep on A", {15'd0, timerOut[1]}, 16'h0001);
    wr(1, 3'd4, 8'h18);
    wr(1, 3'd0, 8'h01);
    tk(4'b0001); idle(1);
    chk("R10 toggle back", {15'd0, timerOut[1]}, 16'h0000);

    // R11 B wins on simultaneous match
    wr(1, 3'd1, 8'h07);
    wr(1, 3'd2, 8'h07);
    wr(1, 3'd4, 8'h48);
    wr(1, 3'd0, 8'h06);
    tk(4'b0001); idle(1);
    chk("R11 B high beats A low", {15'd0, timerOut[1]}, 16'h0001);
    wr(1, 3'd4, 8'h30);
    wr(1, 3'd0, 8'h06);
    tk(4'b0001); idle(1);
    chk("R11 B low beats A high", {15'd0, timerOut[1]}, 16'h0000);

    // R12 paired and byte access
    wrW(3'd0, 16'h12AB);
    rd(0, 3'd0, r); chk("R12 wide high byte to ch0", r, 16'h0012);
    rd(1, 3'd0, r); chk("R12 wide low byte to ch1", r, 16'h00AB);
    wrW(3'd1, 16'h5566);
    rdW(3'd1, r); chk("R12 wide read", r, 16'h5566);
    rd(1, 3'd1, r); chk("R12 byte read upper zero", r, 16'h0066);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end
endmodule